// File: doc/BRIEF.md
# Oversampling Averaging Conversion Controller

This block sits between a host-side trigger and a 12-bit analog-to-digital sample handshake. It averages a power-of-two number of back-to-back samples from one chosen channel and produces a 16-bit result that is always the mean multiplied by 16. The host starts a burst once. The block then keeps its conversion request raised until every sample that the configured ratio needs has arrived. It never needs a second host action.

Completion is reported in one of two ways, chosen when the burst starts. In stall mode, a busy line stays high for the whole burst, so a bus front end can hold its clock low until the result exists. In convert-start mode, busy stays low. The result is then stored in a per-channel recent-result register that can be read as two bytes, and a sticky done flag is set for the host to poll. The bus protocol engine, the converter itself and the analog multiplexer lie outside this block. They are modelled by plain request, valid and data signals.

Top module: `osr_avg_ctrl`

## Requirements
- R1: The 3-bit ratio field `cfg_osr` = k, latched when a burst starts, makes the burst consume exactly 2^k samples (k = 0 gives one sample). `adc_req` is low after the last sample and stays low until the next trigger.
- R2: The result is floor(sum × 16 / 2^k), 16 bits wide for every k. Full-scale input (4095) gives 65520, and k = 0 gives the sample shifted left by four.
- R3: After one trigger, `adc_req` stays high with no further host input until the last sample is taken, and `avg_valid` pulses for one cycle with `avg_data` on the second clock edge after the last accepted sample.
- R4: With `cfg_stats_en` = 0, a `host_start` pulse begins a burst. `busy` rises on the edge that accepts the trigger and falls on the edge that raises `avg_valid`.
- R5: With `cfg_stats_en` = 1, a `cnvst_wr` pulse begins a burst. `busy` stays 0, and the done flag (status bit 0) is set on the edge that raises `avg_valid`.
- R6: In convert-start mode, the result is written to the recent-result register of the latched channel. That register is read at address {1, channel, b}, where b = 1 gives bits 15:8 and b = 0 gives bits 7:0. A stall-mode burst leaves every recent-result register unchanged.
- R7: A read at an address whose top bit is 0 returns status {zeros, busy, done} (busy = bit 1, done = bit 0) one cycle after `rd_en`, and the read clears done. If a completion sets done in the same cycle as a status read, the set wins and that read returns the old value.
- R8: A trigger that starts a new burst clears the done flag.
- R9: While a burst is active, `host_start`, `cnvst_wr` and changes to `cfg_osr` or `cfg_chan` have no effect on it. The trigger belonging to the mode that is not selected starts nothing.
- R10: A synchronous active-high `rst` clears the accumulator, the sample counter, busy, done, `avg_data` and all recent-result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_osr | input | 3 | Averaging ratio exponent, latched at trigger |
| cfg_stats_en | input | 1 | 1 selects convert-start mode, 0 selects stall mode |
| cfg_chan | input | CH_W | Channel to average, latched at trigger |
| host_start | input | 1 | Stall-mode start pulse |
| cnvst_wr | input | 1 | Convert-start write pulse |
| busy | output | 1 | High for the duration of a stall-mode burst |
| adc_req | output | 1 | Conversion request, held until the burst has all its samples |
| adc_chan | output | CH_W | Channel for the converter |
| adc_valid | input | 1 | Sample strobe, counted only while adc_req is high |
| adc_data | input | 12 | Sample value |
| avg_valid | output | 1 | One-cycle result strobe |
| avg_data | output | 16 | Scaled average |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | CH_W+2 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The clearing of done by a status read and the setting of done by a finishing convert-start burst can fall on the same clock edge. The bench provokes this by raising `rd_en` at a status address in exactly the cycle after the final sample is accepted. It judges the result in two steps: that read must return done = 0 together with the `avg_valid` pulse, and the following status read must return done = 1, after which a third read returns 0. The bench also overlaps stray triggers and ratio changes with a running burst, and checks that the sample count and the result still follow the ratio latched at the start.

// File: rtl/osr_avg_pkg.sv
package osr_avg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/osr_avg_seq.sv
module osr_avg_seq #(
  parameter int OSR_W = 3,
  parameter int CH_W  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OSR_W-1:0] cfg_osr,
  input  logic             cfg_stats_en,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             host_start,
  input  logic             cnvst_wr,
  input  logic             adc_valid,
  input  logic             stat_rd,
  output logic             adc_req,
  output logic             busy,
  output logic             done,
  output logic             fin,
  output logic             acc_clr,
  output logic             acc_add,
  output logic [OSR_W-1:0] osr_q,
  output logic [CH_W-1:0]  chan_q,
  output logic             mode_cnv,
  output logic [CNT_W-1:0] smp_cnt,
  output logic [CNT_W-1:0] last_cnt
);
  import osr_avg_pkg::*;

  seq_state_t st;
  logic       trig;

  always_comb begin
    trig     = (st == ST_IDLE) && (cfg_stats_en ? cnvst_wr : host_start);
    acc_clr  = trig;
    acc_add  = (st == ST_RUN) && adc_valid;
    fin      = (st == ST_FIN);
    adc_req  = (st == ST_RUN);
    last_cnt = ({{(CNT_W-1){1'b0}}, 1'b1} << osr_q) - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      osr_q    <= '0;
      chan_q   <= '0;
      mode_cnv <= 1'b0;
      smp_cnt  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (trig) begin
            st       <= ST_RUN;
            osr_q    <= cfg_osr;
            chan_q   <= cfg_chan;
            mode_cnv <= cfg_stats_en;
            busy     <= !cfg_stats_en;
            smp_cnt  <= '0;
          end
        end
        ST_RUN: begin
          if (adc_valid) begin
            if (smp_cnt == last_cnt) begin
              smp_cnt <= '0;
              st      <= ST_FIN;
            end else begin
              smp_cnt <= smp_cnt + 1'b1;
            end
          end
        end
        ST_FIN: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // completion set has priority over the status-read clear
  always_ff @(posedge clk) begin
    if (rst)                done <= 1'b0;
    else if (fin && mode_cnv) done <= 1'b1;
    else if (trig)          done <= 1'b0;
    else if (stat_rd)       done <= 1'b0;
  end

endmodule

// File: rtl/osr_avg_accum.sv
module osr_avg_accum #(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 16,
  parameter int OSR_W    = 3,
  parameter int ACC_W    = 19
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                add,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [OSR_W-1:0]    osr_q,
  input  logic                fin,
  output logic [RESULT_W-1:0] scaled,
  output logic                res_valid,
  output logic [RESULT_W-1:0] res_data
);
  localparam int FRAC   = RESULT_W - SAMPLE_W;
  localparam int WIDE_W = ACC_W + FRAC;

  logic [ACC_W-1:0]  acc;
  logic [WIDE_W-1:0] wide;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (add)   acc <= acc + ACC_W'(sample);
  end

  // sum * 2^FRAC / 2^k : one right shift covers both directions
  always_comb begin
    wide   = {acc, {FRAC{1'b0}}};
    scaled = RESULT_W'(wide >> osr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fin;
      if (fin) res_data <= scaled;
    end
  end

endmodule

// File: rtl/osr_avg_bank.sv
module osr_avg_bank #(
  parameter int NUM_CH   = 8,
  parameter int RESULT_W = 16,
  parameter int CH_W     = 3,
  parameter int RA_W     = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [RESULT_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [RA_W-1:0]     rd_addr,
  input  logic                st_busy,
  input  logic                st_done,
  output logic                stat_rd,
  output logic [7:0]          rd_data
);
  import osr_avg_pkg::*;

  logic [RESULT_W-1:0] regs [NUM_CH];
  logic [RESULT_W-1:0] rd_word;
  logic [CH_W-1:0]     sel_ch;
  logic                is_res;
  logic                hi_byte;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chreg
    always_ff @(posedge clk) begin
      if (rst)                              regs[g] <= '0;
      else if (wr_en && wr_ch == CH_W'(g))  regs[g] <= wr_data;
    end
  end

  always_comb begin
    is_res  = rd_addr[RA_W-1];
    sel_ch  = rd_addr[CH_W:1];
    hi_byte = rd_addr[0];
    stat_rd = rd_en && !is_res;
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ch == CH_W'(i)) rd_word = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (is_res) rd_data <= hi_byte ? rd_word[RESULT_W-1 -: BYTE_W] : rd_word[BYTE_W-1:0];
      else        rd_data <= {{(BYTE_W-2){1'b0}}, st_busy, st_done};
    end
  end

endmodule

// File: rtl/osr_avg_ctrl.sv
module osr_avg_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 16,
  parameter int OSR_W    = 3,
  parameter int NUM_CH   = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W    = CH_W + 2,
  localparam int MAX_K   = (1 << OSR_W) - 1,
  localparam int ACC_W   = SAMPLE_W + MAX_K,
  localparam int CNT_W   = MAX_K + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OSR_W-1:0]    cfg_osr,
  input  logic                cfg_stats_en,
  input  logic [CH_W-1:0]     cfg_chan,
  input  logic                host_start,
  input  logic                cnvst_wr,
  output logic                busy,
  output logic                adc_req,
  output logic [CH_W-1:0]     adc_chan,
  input  logic                adc_valid,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                avg_valid,
  output logic [RESULT_W-1:0] avg_data,
  input  logic                rd_en,
  input  logic [RA_W-1:0]     rd_addr,
  output logic [7:0]          rd_data
);

  logic             done_q, fin, acc_clr, acc_add, mode_cnv, stat_rd;
  logic [OSR_W-1:0] osr_q;
  logic [CNT_W-1:0] smp_cnt, last_cnt;
  logic [RESULT_W-1:0] scaled;

  osr_avg_seq #(.OSR_W(OSR_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .cfg_osr(cfg_osr), .cfg_stats_en(cfg_stats_en),
    .cfg_chan(cfg_chan), .host_start(host_start), .cnvst_wr(cnvst_wr),
    .adc_valid(adc_valid), .stat_rd(stat_rd), .adc_req(adc_req), .busy(busy),
    .done(done_q), .fin(fin), .acc_clr(acc_clr), .acc_add(acc_add),
    .osr_q(osr_q), .chan_q(adc_chan), .mode_cnv(mode_cnv),
    .smp_cnt(smp_cnt), .last_cnt(last_cnt)
  );

  osr_avg_accum #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W), .OSR_W(OSR_W),
                  .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add), .sample(adc_data),
    .osr_q(osr_q), .fin(fin), .scaled(scaled), .res_valid(avg_valid),
    .res_data(avg_data)
  );

  osr_avg_bank #(.NUM_CH(NUM_CH), .RESULT_W(RESULT_W), .CH_W(CH_W),
                 .RA_W(RA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(fin && mode_cnv), .wr_ch(adc_chan),
    .wr_data(scaled), .rd_en(rd_en), .rd_addr(rd_addr), .st_busy(busy),
    .st_done(done_q), .stat_rd(stat_rd), .rd_data(rd_data)
  );

endmodule

// File: rtl/osr_avg_chk.sv
module osr_avg_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             adc_req,
  input logic             avg_valid,
  input logic             done,
  input logic             mode_cnv,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last_cnt
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> cnt <= last_cnt);                                  // R1

  AST_NO_REQ_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    avg_valid |-> !adc_req);                                       // R3

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    avg_valid |=> !avg_valid);                                     // R3

  AST_BUSY_DROPS_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> avg_valid);                                    // R4

  AST_BUSY_STALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mode_cnv);                                           // R5

  AST_DONE_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> avg_valid);                                    // R5

endmodule

bind osr_avg_ctrl osr_avg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .adc_req(adc_req),
  .avg_valid(avg_valid), .done(done_q), .mode_cnv(mode_cnv),
  .cnt(smp_cnt), .last_cnt(last_cnt)
);

// File: tb/tb_osr_avg_ctrl.sv
module tb_osr_avg_ctrl;
  localparam int NCH  = 4;
  localparam int CHW  = 2;
  localparam int RAW  = CHW + 2;

  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  cfg_osr = '0;
  logic        cfg_stats_en = 0;
  logic [CHW-1:0] cfg_chan = '0;
  logic        host_start = 0, cnvst_wr = 0;
  logic        busy, adc_req, adc_valid = 0, avg_valid, rd_en = 0;
  logic [CHW-1:0] adc_chan;
  logic [11:0] adc_data = '0;
  logic [15:0] avg_data;
  logic [RAW-1:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  int exp_bank [NCH];

  osr_avg_ctrl #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .cfg_osr(cfg_osr), .cfg_stats_en(cfg_stats_en),
    .cfg_chan(cfg_chan), .host_start(host_start), .cnvst_wr(cnvst_wr),
    .busy(busy), .adc_req(adc_req), .adc_chan(adc_chan), .adc_valid(adc_valid),
    .adc_data(adc_data), .avg_valid(avg_valid), .avg_data(avg_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int smp(input int pat, input int i, input int salt);
    logic [31:0] t;
    case (pat)
      0: return 0;
      1: return 4095;
      2: return (i * 37 + salt * 11) % 4096;
      default: begin
        t = 32'(i + 1) * 32'd2654435761 ^ 32'(salt * 40503);
        return int'(t[19:8]);
      end
    endcase
  endfunction

  task automatic rd(input int a, output int d);
    rd_en = 1; rd_addr = RAW'(a);
    @(negedge clk);
    d = int'(rd_data); rd_en = 0;
  endtask

  function automatic int res_addr(input int ch, input int hi);
    return (1 << (CHW + 1)) | (ch << 1) | hi;
  endfunction

  task automatic wait_req(output bit got);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      if (adc_req) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_burst(input bit cnv, input int osr, input int ch,
                           input int pat, input bit disturb, input bit rd_stat);
    int n, ex, d, lo, hi;
    longint sum;
    bit got, seen;
    n = 1 << osr; sum = 0;
    cfg_osr = 3'(osr); cfg_stats_en = cnv; cfg_chan = CHW'(ch);
    if (cnv) cnvst_wr = 1; else host_start = 1;
    @(negedge clk);
    cnvst_wr = 0; host_start = 0;
    for (int i = 0; i < n; i++) begin
      wait_req(got);
      chk("R3 request held without host action", int'(got), 1);
      if (!got) return;
      if (i == 0) chk("R4 R5 busy level during burst", int'(busy), cnv ? 0 : 1);
      if (disturb && i == 1) begin
        host_start = 1; cnvst_wr = 1;
        cfg_osr = 3'(osr ^ 7); cfg_chan = CHW'(ch + 1);
        @(negedge clk);
        host_start = 0; cnvst_wr = 0;
      end
      repeat (i % 3) @(negedge clk);
      adc_valid = 1; adc_data = 12'(smp(pat, i, osr + ch));
      sum += smp(pat, i, osr + ch);
      @(negedge clk);
      adc_valid = 0;
    end
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      if (avg_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    ex = int'(((sum << 4) >> osr) & 64'hFFFF);
    chk("R3 result strobe", int'(seen), 1);
    chk(disturb ? "R9 R2 result despite disturbance" : "R2 scaled average", int'(avg_data), ex);
    chk("R4 busy low at result", int'(busy), 0);
    cfg_osr = 3'(osr); cfg_chan = CHW'(ch);
    @(negedge clk);
    got = 0;
    repeat (3) begin
      if (adc_req) got = 1;
      @(negedge clk);
    end
    chk("R1 no request beyond 2^k samples", int'(got), 0);
    if (cnv) exp_bank[ch] = ex;
    rd(res_addr(ch, 1), hi);
    rd(res_addr(ch, 0), lo);
    chk(cnv ? "R6 recent result written" : "R6 stall leaves bank unchanged",
        (hi << 8) | lo, exp_bank[ch]);
    if (rd_stat) begin
      rd(0, d);
      chk("R5 R7 status after burst", d, cnv ? 1 : 0);
      rd(0, d);
      chk("R7 status read clears done", d, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    for (int c = 0; c < NCH; c++) exp_bank[c] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 adc_req after reset", int'(adc_req), 0);
    chk("R10 avg_data after reset", int'(avg_data), 0);
    rd(0, d);
    chk("R10 status after reset", d, 0);
    for (int c = 0; c < NCH; c++) begin
      for (int h = 0; h < 2; h++) begin
        rd(res_addr(c, h), d);
        chk("R10 result bank after reset", d, 0);
      end
    end

    // sweep: both modes, every ratio, several input patterns
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 8; k++)
        for (int p = 0; p < 4; p++)
          run_burst(m[0], k, (k + p) % NCH, p, (p == 2) && (k >= 1), 1'b1);

    // R9 wrong-mode triggers start nothing
    cfg_stats_en = 0; cnvst_wr = 1; @(negedge clk); cnvst_wr = 0;
    repeat (3) @(negedge clk);
    chk("R9 cnvst ignored in stall mode", int'(adc_req | busy), 0);
    cfg_stats_en = 1; host_start = 1; @(negedge clk); host_start = 0;
    repeat (3) @(negedge clk);
    chk("R9 host_start ignored in convert-start mode", int'(adc_req | busy), 0);

    // R7 completion and status read in the same cycle
    cfg_osr = 0; cfg_stats_en = 1; cfg_chan = 2'd3;
    cnvst_wr = 1; @(negedge clk); cnvst_wr = 0;
    adc_valid = 1; adc_data = 12'h5A5; @(negedge clk);
    adc_valid = 0; rd_en = 1; rd_addr = '0; @(negedge clk);
    rd_en = 0;
    chk("R7 coincident read returns old done", int'(rd_data), 0);
    chk("R2 single-sample result", int'(avg_data), 16'h5A50);
    exp_bank[3] = 16'h5A50;
    rd(0, d);
    chk("R7 set wins over coincident clear", d, 1);
    rd(0, d);
    chk("R7 cleared by next read", d, 0);

    // R8 new burst clears done
    run_burst(1'b1, 1, 1, 3, 1'b0, 1'b0);
    cfg_osr = 0; cfg_chan = 2'd1;
    cnvst_wr = 1; @(negedge clk); cnvst_wr = 0;
    rd(0, d);
    chk("R8 done cleared by new trigger", d, 0);
    adc_valid = 1; adc_data = 12'd7; @(negedge clk);
    adc_valid = 0; repeat (2) @(negedge clk);
    rd(0, d);
    chk("R5 done after second burst", d, 1);

    // R10 reset clears stored results
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    for (int c = 0; c < NCH; c++) begin
      rd(res_addr(c, 1), d);
      chk("R10 bank cleared by reset", d, 0);
    end
    rd(0, d);
    chk("R10 done cleared by reset", d, 0);
    chk("R10 avg_data cleared by reset", int'(avg_data), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule